// File: doc/BRIEF.md
# Multi-Line Receive Character Capture

This block collects received characters from a bank of serial receivers (sixteen by default) into one holding word that a host reads. While the holding word is empty, the block scans every cycle for eligible lines. A line is eligible when its receiver offers a character and the line's receive-rate setting is nonzero. The lowest-numbered eligible line wins. Its character is trimmed to the line's configured character length and packed with the line number and a data-present marker. The winning receiver gets a one-cycle ready pulse, and the receive flag rises.

The block is built around a two-state machine. `ST_SCAN` means the holding word is empty and the block is looking for a character. `ST_HOLD` means a character is waiting for the host. There are three transitions. `T_CAPTURE` goes from `ST_SCAN` to `ST_HOLD` when any line is eligible. `T_RELEASE` goes from `ST_HOLD` to `ST_SCAN` when the host read strobe arrives. `T_CLEAR` goes from any state to `ST_SCAN` when master clear is asserted. The receive interrupt is the receive flag gated by the interrupt enable.

A read strobe is destructive: the host takes `rd_data` in the strobe cycle, and the word is empty from the next cycle on. Characters on lines that lost the scan stay in their receivers until a later scan picks them up.

Top module: `rxcap_top`

## Requirements
- R1: After reset, `rd_data` is 0x0000 and `rx_flag` and `irq` are low.
- R2: A captured word has bit 15 set, bits 14:12 clear, the source line number in bits 11:8 and the trimmed character in bits 7:0.
- R3: The character is trimmed to (length code + 5) bits using the line's 2-bit `cfg_len`: codes 0, 1, 2 and 3 keep 5, 6, 7 and 8 low bits. The bits above are zero.
- R4: When several lines are eligible in the same scan cycle, the lowest-numbered line is captured.
- R5: `rx_ready` is at most one-hot. It is high only for the captured line, only in the cycle of capture, and only while that line's `rx_valid` is high.
- R6: A capture sets `rx_flag` from the next cycle on. `irq` equals `rx_flag` AND `rx_ie`.
- R7: While `rx_flag` is high, no line gets `rx_ready` and `rd_data` stays unchanged unless a read or master clear occurs.
- R8: A `rd_strobe` while `rx_flag` is high clears `rd_data` and `rx_flag` in the next cycle, and scanning resumes from that cycle.
- R9: A line whose 4-bit `cfg_rate` is zero is never captured and never gets `rx_ready`, even when its `rx_valid` is high.
- R10: A `rd_strobe` while the holding word is empty has no effect: the word stays 0 and the next character is still captured.
- R11: `mclr` empties the holding word and drops `rx_flag` and `irq` from the next cycle. No `rx_ready` is given in a cycle with `mclr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_valid | input | 16 | Per-line character offered |
| rx_char | input | 16x8 | Per-line received character |
| cfg_len | input | 16x2 | Per-line character length code |
| cfg_rate | input | 16x4 | Per-line receive rate; zero disables the line |
| rx_ready | output | 16 | Per-line one-cycle accept pulse |
| rd_strobe | input | 1 | Host destructive read of the holding word |
| rd_data | output | 16 | Holding word |
| rx_flag | output | 1 | Character waiting |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest situation to reach is a line that loses the scan and then has to wait through a full hold period before it is picked. Only a character that stays offered across a read cycle shows this. The bench raises two lines in the same cycle, withdraws only the winner after its handshake, and holds the loser while the block sits in `ST_HOLD`. It then checks that the loser gets no ready until the read, and gets its ready in the first scan cycle after the read.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } rxcap_state_e;

    localparam int PRESENT_BIT = 15;
    localparam int LINE_LSB    = 8;
    localparam int LEN_BASE    = 5;
endpackage

// File: rtl/rxcap_pick.sv
module rxcap_pick #(
    parameter int NLINES = 16,
    localparam int LNW   = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] req,
    output logic [NLINES-1:0] gnt,
    output logic [LNW-1:0]    idx,
    output logic              any
);
    // Walk from the top down so the lowest requesting line is assigned last.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = LNW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxcap_fmt.sv
module rxcap_fmt
    import rxcap_pkg::*;
#(
    parameter int CHW   = 8,
    parameter int LENW  = 2,
    parameter int LNW   = 4,
    parameter int WORDW = 16
) (
    input  logic [CHW-1:0]   chr,
    input  logic [LENW-1:0]  len,
    input  logic [LNW-1:0]   line,
    output logic [WORDW-1:0] word
);
    logic [CHW-1:0] keep;

    // Bit b is kept when it lies below the configured character length.
    for (genvar b = 0; b < CHW; b++) begin : g_keep
        assign keep[b] = (32'(b) < (32'(LEN_BASE) + 32'(len)));
    end

    always_comb begin
        word                   = '0;
        word[CHW-1:0]          = chr & keep;
        word[LINE_LSB +: LNW]  = line;
        word[PRESENT_BIT]      = 1'b1;
    end
endmodule

// File: rtl/rxcap_top.sv
module rxcap_top
    import rxcap_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int CHW    = 8,
    parameter int LENW   = 2,
    parameter int RATEW  = 4,
    parameter int WORDW  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mclr,
    input  logic                         rx_ie,
    input  logic [NLINES-1:0]            rx_valid,
    input  logic [NLINES-1:0][CHW-1:0]   rx_char,
    input  logic [NLINES-1:0][LENW-1:0]  cfg_len,
    input  logic [NLINES-1:0][RATEW-1:0] cfg_rate,
    output logic [NLINES-1:0]            rx_ready,
    input  logic                         rd_strobe,
    output logic [WORDW-1:0]             rd_data,
    output logic                         rx_flag,
    output logic                         irq
);
    localparam int LNW = $clog2(NLINES);

    rxcap_state_e      state_q, state_d;
    logic [NLINES-1:0] eligible;
    logic [NLINES-1:0] gnt;
    logic [LNW-1:0]    win_idx;
    logic              win_any;
    logic [WORDW-1:0]  cap_word;
    logic [WORDW-1:0]  hold_q;

    // A line takes part in the scan only with a nonzero rate setting.
    for (genvar i = 0; i < NLINES; i++) begin : g_elig
        assign eligible[i] = rx_valid[i] & (|cfg_rate[i]);
    end

    rxcap_pick #(.NLINES(NLINES)) u_pick (
        .req (eligible),
        .gnt (gnt),
        .idx (win_idx),
        .any (win_any)
    );

    rxcap_fmt #(.CHW(CHW), .LENW(LENW), .LNW(LNW), .WORDW(WORDW)) u_fmt (
        .chr  (rx_char[win_idx]),
        .len  (cfg_len[win_idx]),
        .line (win_idx),
        .word (cap_word)
    );

    // Transitions: T_CLEAR (mclr), T_CAPTURE (scan hit), T_RELEASE (read).
    always_comb begin
        state_d = state_q;
        if (mclr) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_SCAN: if (win_any)   state_d = ST_HOLD;
                ST_HOLD: if (rd_strobe) state_d = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (mclr) begin
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_SCAN: if (win_any)   hold_q <= cap_word;
                ST_HOLD: if (rd_strobe) hold_q <= '0;
            endcase
        end
    end

    always_comb begin
        rx_ready = '0;
        rx_flag  = 1'b0;
        unique case (state_q)
            ST_SCAN: if (!mclr) rx_ready = gnt;
            ST_HOLD: rx_flag = 1'b1;
        endcase
        irq     = rx_flag & rx_ie;
        rd_data = hold_q;
    end
endmodule

// File: rtl/rxcap_chk.sv
module rxcap_chk #(
    parameter int NLINES = 16,
    parameter int WORDW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mclr,
    input logic              rx_ie,
    input logic [NLINES-1:0] rx_valid,
    input logic [NLINES-1:0] rx_ready,
    input logic              rd_strobe,
    input logic [WORDW-1:0]  rd_data,
    input logic              rx_flag,
    input logic              irq
);
    a_r5_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_ready));

    a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready & ~rx_valid) == '0);

    a_r2_capture_marks_word: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_ready) |=> (rx_flag && rd_data[15]));

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_flag && rx_ie));

    a_r7_no_ready_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |-> (rx_ready == '0));

    a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rd_strobe && !mclr) |=> $stable(rd_data));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && rd_strobe) |=> (!rx_flag && rd_data == '0));

    a_r11_mclr_empties: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (!rx_flag && !irq && rd_data == '0));

    a_r11_no_ready_in_mclr: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |-> (rx_ready == '0));
endmodule

bind rxcap_top rxcap_chk #(.NLINES(NLINES), .WORDW(WORDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .rx_ie     (rx_ie),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rx_flag   (rx_flag),
    .irq       (irq)
);

// File: tb/sim_rxcap_top.sv
module sim_rxcap_top;
    localparam int N = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 mclr = 1'b0;
    logic                 rx_ie = 1'b0;
    logic [N-1:0]         rx_valid = '0;
    logic [N-1:0][7:0]    rx_char = '0;
    logic [N-1:0][1:0]    cfg_len = '1;
    logic [N-1:0][3:0]    cfg_rate;
    logic [N-1:0]         rx_ready;
    logic                 rd_strobe = 1'b0;
    logic [15:0]          rd_data;
    logic                 rx_flag;
    logic                 irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxcap_top u0 (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .rx_ie(rx_ie),
        .rx_valid(rx_valid), .rx_char(rx_char), .cfg_len(cfg_len),
        .cfg_rate(cfg_rate), .rx_ready(rx_ready), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_flag(rx_flag), .irq(irq)
    );

    // {line[33:30], len[29:28], rate[27:24], char[23:16], expected word[15:0]}
    localparam logic [33:0] VEC [8] = '{
        {4'd0,  2'd3, 4'h1, 8'hA5, 16'h80A5},
        {4'd1,  2'd0, 4'h2, 8'hFF, 16'h811F},
        {4'd2,  2'd1, 4'hF, 8'hC7, 16'h8207},
        {4'd5,  2'd2, 4'h3, 8'hFF, 16'h857F},
        {4'd15, 2'd3, 4'h8, 8'h3C, 16'h8F3C},
        {4'd7,  2'd0, 4'h1, 8'hE5, 16'h8705},
        {4'd10, 2'd1, 4'h4, 8'h5A, 16'h8A1A},
        {4'd12, 2'd2, 4'h1, 8'h80, 16'h8C00}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) cfg_rate[i] = 4'h1;
        tick();
        tick();
        // R1 reset state
        check("R1 word", 32'(rd_data), 32'h0);
        check("R1 flag", 32'(rx_flag), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        tick();
        rx_ie = 1'b1;

        // Table walk: R2 format, R3 trim, R5 handshake, R6 flag/irq, R8 read
        for (int v = 0; v < 8; v++) begin
            logic [3:0] ln;
            ln = VEC[v][33:30];
            cfg_len[ln]  = VEC[v][29:28];
            cfg_rate[ln] = VEC[v][27:24];
            rx_char[ln]  = VEC[v][23:16];
            rx_valid[ln] = 1'b1;
            #1;
            check("R5 ready pulse", 32'(rx_ready), 32'(1) << ln);
            tick();
            rx_valid[ln] = 1'b0;
            check("R2 R3 captured word", 32'(rd_data), 32'(VEC[v][15:0]));
            check("R6 flag", 32'(rx_flag), 32'h1);
            check("R6 irq", 32'(irq), 32'h1);
            host_read();
            check("R8 word cleared", 32'(rd_data), 32'h0);
            check("R8 flag cleared", 32'(rx_flag), 32'h0);
        end
        cfg_len  = '1;
        for (int i = 0; i < N; i++) cfg_rate[i] = 4'h1;

        // R4 priority, R7 hold, R8 resume
        rx_char[3] = 8'h33;
        rx_char[9] = 8'h99;
        rx_valid[3] = 1'b1;
        rx_valid[9] = 1'b1;
        #1;
        check("R4 lowest line ready", 32'(rx_ready), 32'h0008);
        tick();
        rx_valid[3] = 1'b0;
        check("R4 lowest line word", 32'(rd_data), 32'h8333);
        for (int k = 0; k < 3; k++) begin
            check("R7 no ready while held", 32'(rx_ready), 32'h0);
            tick();
        end
        check("R7 word kept", 32'(rd_data), 32'h8333);
        host_read();
        check("R8 resume ready", 32'(rx_ready), 32'h0200);
        tick();
        rx_valid[9] = 1'b0;
        check("R8 waiting line captured", 32'(rd_data), 32'h8999);
        host_read();

        // R9 zero rate disables a line
        cfg_rate[4] = 4'h0;
        rx_char[4]  = 8'h44;
        rx_valid[4] = 1'b1;
        #1;
        check("R9 no ready", 32'(rx_ready), 32'h0);
        tick();
        tick();
        check("R9 no capture", 32'(rx_flag), 32'h0);
        cfg_rate[4] = 4'h1;
        #1;
        check("R9 ready after rate set", 32'(rx_ready), 32'h0010);
        tick();
        rx_valid[4] = 1'b0;
        check("R9 captured after rate set", 32'(rd_data), 32'h8444);
        host_read();

        // R10 strobe while empty
        host_read();
        check("R10 word still empty", 32'(rd_data), 32'h0);
        rx_char[6] = 8'h16;
        rx_valid[6] = 1'b1;
        tick();
        rx_valid[6] = 1'b0;
        check("R10 capture after empty read", 32'(rd_data), 32'h8616);

        // R6 irq gating while held
        rx_ie = 1'b0;
        #1;
        check("R6 irq off", 32'(irq), 32'h0);
        check("R6 flag held", 32'(rx_flag), 32'h1);
        rx_ie = 1'b1;
        #1;
        check("R6 irq on", 32'(irq), 32'h1);

        // R11 master clear drops held char
        mclr = 1'b1;
        tick();
        mclr = 1'b0;
        check("R11 word", 32'(rd_data), 32'h0);
        check("R11 flag", 32'(rx_flag), 32'h0);
        check("R11 irq", 32'(irq), 32'h0);

        // R11 no handshake during master clear
        rx_valid[2] = 1'b1;
        rx_char[2]  = 8'h22;
        mclr = 1'b1;
        #1;
        check("R11 no ready in clear", 32'(rx_ready), 32'h0);
        tick();
        check("R11 nothing captured", 32'(rx_flag), 32'h0);
        mclr = 1'b0;
        tick();
        rx_valid[2] = 1'b0;
        check("R11 capture after clear", 32'(rd_data), 32'h8222);
        host_read();

        finish_run();
    end
endmodule